// File: doc/BRIEF.md
# 64-bit Register Shift Unit

This block is the shift datapath of a 64-bit integer execution stage. It takes one operand, a second register value that may supply the shift count, a 5-bit immediate count and a 4-bit operation code. From these it produces the shifted 64-bit result in the same cycle. It holds no state. Instruction decode, the register file and writeback sit outside it.

There are fifteen operation codes. Each picks a direction (left, logical right or arithmetic right), a width and a count source. The width is either the low 32-bit word or the full 64-bit doubleword. The count comes from the immediate, from the immediate plus 32, or from the register.

Word forms shift only the low 32 bits of the operand. They then sign-extend bit 31 of the word result to 64 bits. This holds even for the logical right shift, which can therefore return a negative value when the count is zero. Doubleword forms reach every count from 0 to 63, either through the register or through the immediate-plus-32 codes.

Top module: `bshift64_unit`

## Requirements
- R1: Operation codes are as follows. Word shifts: 0 is left, 1 is logical right and 2 is arithmetic right, all by immediate; 3, 4 and 5 are the same three by register. Doubleword shifts: 6, 7 and 8 are left, logical right and arithmetic right by immediate; 9, 10 and 11 are the same three by 32 plus immediate; 12, 13 and 14 are the same three by register. Code 15 is unused.
- R2: Word forms read only operand bits 31:0. Operand bits 63:32 have no effect on the result.
- R3: A word form returns its 32-bit result in bits 31:0, with bit 31 copied into bits 63:32. This includes the logical right shift.
- R4: Word register forms (codes 3, 4 and 5) take the count from shift-source bits 4:0. Higher shift-source bits are ignored.
- R5: Doubleword register forms (codes 12, 13 and 14) take the count from shift-source bits 5:0. Higher shift-source bits are ignored.
- R6: Doubleword immediate forms (codes 6, 7 and 8) shift by the immediate, 0 to 31. Codes 9, 10 and 11 shift by 32 plus the immediate, 32 to 63.
- R7: An arithmetic right shift fills vacated bits with the sign bit: bit 31 for word forms, bit 63 for doubleword forms. A logical right shift fills with zeros, and so does a left shift.
- R8: A count of zero returns the operand unchanged for doubleword forms, and returns the sign-extended low word for word forms.
- R9: Code 15 returns all zeros, whatever the other inputs are.
- R10: Register forms ignore the immediate input. Immediate forms ignore the shift-source input.
- R11: The result is purely combinational and follows the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select, encoded as in R1 |
| operand | input | 64 | Value to be shifted |
| shamt_src | input | 64 | Register value supplying the count for register forms |
| imm_cnt | input | 5 | Immediate shift count |
| result | output | 64 | Shifted and, for word forms, sign-extended result |

## Verification
Two rules meet in one evaluation: the word-width logical right shift and the sign extension of its 32-bit result. When operand bit 31 is set and the count is zero, the logical shift leaves bit 31 in place, and the extension must then fill the upper half with ones. With any non-zero count, bit 31 clears and the upper half must be zero. Directed vectors with bit 31 set are applied at counts 0 and 1, and the count sweeps cover every word count. Each result is judged against a bench model that shifts a 32-bit value and then extends it.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  // direction of a shift
  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } sh_kind_e;

  // where the count comes from
  typedef enum logic [1:0] {
    AMT_IMM    = 2'd0,
    AMT_IMM_HI = 2'd1,
    AMT_REG    = 2'd2
  } amt_src_e;

  typedef struct packed {
    logic     valid;
    logic     word;
    sh_kind_e kind;
    amt_src_e asrc;
  } op_dec_t;

  localparam logic [3:0] OP_WSLL_I  = 4'd0;
  localparam logic [3:0] OP_WSRL_I  = 4'd1;
  localparam logic [3:0] OP_WSRA_I  = 4'd2;
  localparam logic [3:0] OP_WSLL_R  = 4'd3;
  localparam logic [3:0] OP_WSRL_R  = 4'd4;
  localparam logic [3:0] OP_WSRA_R  = 4'd5;
  localparam logic [3:0] OP_DSLL_I  = 4'd6;
  localparam logic [3:0] OP_DSRL_I  = 4'd7;
  localparam logic [3:0] OP_DSRA_I  = 4'd8;
  localparam logic [3:0] OP_DSLL_H  = 4'd9;
  localparam logic [3:0] OP_DSRL_H  = 4'd10;
  localparam logic [3:0] OP_DSRA_H  = 4'd11;
  localparam logic [3:0] OP_DSLL_R  = 4'd12;
  localparam logic [3:0] OP_DSRL_R  = 4'd13;
  localparam logic [3:0] OP_DSRA_R  = 4'd14;
  localparam logic [3:0] OP_NONE    = 4'd15;

  function automatic op_dec_t mk_dec(input logic w, input sh_kind_e k, input amt_src_e s);
    op_dec_t d;
    d.valid = 1'b1;
    d.word  = w;
    d.kind  = k;
    d.asrc  = s;
    return d;
  endfunction

  // opcode -> control fields
  function automatic op_dec_t decode_op(input logic [3:0] code);
    op_dec_t d;
    d = '0;
    unique case (code)
      OP_WSLL_I: d = mk_dec(1'b1, SH_LEFT, AMT_IMM);
      OP_WSRL_I: d = mk_dec(1'b1, SH_RLOG, AMT_IMM);
      OP_WSRA_I: d = mk_dec(1'b1, SH_RARI, AMT_IMM);
      OP_WSLL_R: d = mk_dec(1'b1, SH_LEFT, AMT_REG);
      OP_WSRL_R: d = mk_dec(1'b1, SH_RLOG, AMT_REG);
      OP_WSRA_R: d = mk_dec(1'b1, SH_RARI, AMT_REG);
      OP_DSLL_I: d = mk_dec(1'b0, SH_LEFT, AMT_IMM);
      OP_DSRL_I: d = mk_dec(1'b0, SH_RLOG, AMT_IMM);
      OP_DSRA_I: d = mk_dec(1'b0, SH_RARI, AMT_IMM);
      OP_DSLL_H: d = mk_dec(1'b0, SH_LEFT, AMT_IMM_HI);
      OP_DSRL_H: d = mk_dec(1'b0, SH_RLOG, AMT_IMM_HI);
      OP_DSRA_H: d = mk_dec(1'b0, SH_RARI, AMT_IMM_HI);
      OP_DSLL_R: d = mk_dec(1'b0, SH_LEFT, AMT_REG);
      OP_DSRL_R: d = mk_dec(1'b0, SH_RLOG, AMT_REG);
      OP_DSRA_R: d = mk_dec(1'b0, SH_RARI, AMT_REG);
      default:   d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int CNT_W = 6,
  localparam int IMM_W = CNT_W - 1
) (
  input  logic [3:0]       op_code,
  input  logic [IMM_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] src_lo,
  output op_dec_t          dec,
  output logic [CNT_W-1:0] cnt
);

  assign dec = decode_op(op_code);

  // count selection; word forms never exceed the half width
  always_comb begin
    unique case (dec.asrc)
      AMT_IMM:    cnt = {1'b0, imm_cnt};
      AMT_IMM_HI: cnt = {1'b1, imm_cnt};
      AMT_REG:    cnt = dec.word ? {1'b0, src_lo[IMM_W-1:0]} : src_lo;
      default:    cnt = '0;
    endcase
    if (!dec.valid) cnt = '0;
  end

endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic              left,
  input  logic              fill,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] din_or;
  logic [DATA_W-1:0] stage [CNT_W+1];
  logic              fill_eff;

  assign fill_eff = left ? 1'b0 : fill;

  // left shifts run through the right shifter on a bit-reversed operand
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign din_or[i] = left ? din[DATA_W-1-i] : din[i];
  end

  assign stage[0] = din_or;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = cnt[s] ? {{SH{fill_eff}}, stage[s][DATA_W-1:SH]} : stage[s];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
    assign dout[i] = left ? stage[CNT_W][DATA_W-1-i] : stage[CNT_W][i];
  end

endmodule

// File: rtl/bshift_format.sv
module bshift_format #(
  parameter int DATA_W = 64,
  localparam int HALF = DATA_W / 2
) (
  input  logic              valid,
  input  logic              word,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] dout
);

  always_comb begin
    if (!valid)     dout = '0;
    else if (word)  dout = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    else            dout = raw;
  end

endmodule

// File: rtl/bshift64_unit.sv
module bshift64_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int IMM_W = CNT_W - 1,
  localparam int HALF  = DATA_W / 2
) (
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] shamt_src,
  input  logic [IMM_W-1:0]  imm_cnt,
  output logic [DATA_W-1:0] result
);

  op_dec_t           dec;
  logic [CNT_W-1:0]  shift_cnt;
  logic              dec_word;
  logic              dec_valid;
  logic              fill_bit;
  logic [DATA_W-1:0] core_in;
  logic [DATA_W-1:0] core_out;
  logic              src_hi_unused;

  assign src_hi_unused = ^shamt_src[DATA_W-1:CNT_W];

  bshift_decode #(.CNT_W(CNT_W)) u_dec (
    .op_code (op_code),
    .imm_cnt (imm_cnt),
    .src_lo  (shamt_src[CNT_W-1:0]),
    .dec     (dec),
    .cnt     (shift_cnt)
  );

  assign dec_word  = dec.word;
  assign dec_valid = dec.valid;

  // sign source depends on width; only arithmetic shifts use it
  always_comb begin
    fill_bit = 1'b0;
    if (dec.kind == SH_RARI) fill_bit = dec.word ? operand[HALF-1] : operand[DATA_W-1];
  end

  // word forms: isolate the low word, pre-fill the upper half for right shifts
  always_comb begin
    if (dec.word) begin
      if (dec.kind == SH_LEFT) core_in = {{HALF{1'b0}}, operand[HALF-1:0]};
      else                     core_in = {{HALF{fill_bit}}, operand[HALF-1:0]};
    end else begin
      core_in = operand;
    end
  end

  bshift_core #(.DATA_W(DATA_W)) u_core (
    .din  (core_in),
    .left (dec.kind == SH_LEFT),
    .fill (fill_bit),
    .cnt  (shift_cnt),
    .dout (core_out)
  );

  bshift_format #(.DATA_W(DATA_W)) u_fmt (
    .valid (dec_valid),
    .word  (dec_word),
    .raw   (core_out),
    .dout  (result)
  );

endmodule

// File: rtl/bshift64_unit_chk.sv
module bshift64_unit_chk #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W),
  localparam int IMM_W = CNT_W - 1,
  localparam int HALF  = DATA_W / 2
) (
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] shamt_src,
  input logic [IMM_W-1:0]  imm_cnt,
  input logic [DATA_W-1:0] result,
  input logic [CNT_W-1:0]  shift_cnt,
  input logic              dec_word,
  input logic              dec_valid,
  input logic              fill_bit,
  input logic [DATA_W-1:0] core_out
);

  logic is_wreg, is_dreg, is_hi, is_drlog, is_drari;

  assign is_wreg  = (op_code >= 4'd3)  && (op_code <= 4'd5);
  assign is_dreg  = (op_code >= 4'd12) && (op_code <= 4'd14);
  assign is_hi    = (op_code >= 4'd9)  && (op_code <= 4'd11);
  assign is_drlog = (op_code == 4'd7) || (op_code == 4'd10) || (op_code == 4'd13);
  assign is_drari = (op_code == 4'd8) || (op_code == 4'd11) || (op_code == 4'd14);

  always_comb begin
    assert_word_sext_R3: assert (!(dec_valid && dec_word) ||
      (result[DATA_W-1:HALF] == {HALF{core_out[HALF-1]}}))
      else $error("word result not sign-extended");
    assert_word_reg_cnt_R4: assert (!is_wreg || shift_cnt == {1'b0, shamt_src[IMM_W-1:0]})
      else $error("word register count wrong");
    assert_dword_reg_cnt_R5: assert (!is_dreg || shift_cnt == shamt_src[CNT_W-1:0])
      else $error("doubleword register count wrong");
    assert_hi_imm_cnt_R6: assert (!is_hi || shift_cnt == {1'b1, imm_cnt})
      else $error("high immediate count wrong");
    assert_logic_fill_R7: assert (!(is_drlog && shift_cnt != '0) || !result[DATA_W-1])
      else $error("logical right shift did not zero-fill");
    assert_arith_fill_R7: assert (!(is_drari && shift_cnt != '0) ||
      (result[DATA_W-1] == operand[DATA_W-1] && fill_bit == operand[DATA_W-1]))
      else $error("arithmetic right shift lost the sign");
    assert_passthru_R8: assert (!(dec_valid && !dec_word && shift_cnt == '0) || result == operand)
      else $error("zero count altered operand");
    assert_unused_code_R9: assert (op_code != 4'd15 || (result == '0 && !dec_valid))
      else $error("unused code produced data");
  end

endmodule

bind bshift64_unit bshift64_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .op_code   (op_code),
  .operand   (operand),
  .shamt_src (shamt_src),
  .imm_cnt   (imm_cnt),
  .result    (result),
  .shift_cnt (shift_cnt),
  .dec_word  (dec_word),
  .dec_valid (dec_valid),
  .fill_bit  (fill_bit),
  .core_out  (core_out)
);

// File: tb/bshift64_unit_tb.sv
`timescale 1ns/1ps
module bshift64_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op;
  logic [63:0] a, s, y;
  logic [4:0]  imm;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bshift64_unit u_dut (
    .op_code   (op),
    .operand   (a),
    .shamt_src (s),
    .imm_cnt   (imm),
    .result    (y)
  );

  // independent model written straight from the requirements
  function automatic logic [63:0] model(input logic [3:0] c, input logic [63:0] x,
                                        input logic [63:0] r, input logic [4:0] im);
    logic signed [31:0] ws;
    logic signed [63:0] ds;
    logic [31:0] w;
    int n;
    ws = x[31:0];
    ds = x;
    if (c <= 4'd5) begin
      n = (c <= 4'd2) ? int'(im) : int'(r[4:0]);
      case (c % 3)
        0:       w = x[31:0] << n;
        1:       w = x[31:0] >> n;
        default: w = ws >>> n;
      endcase
      return {{32{w[31]}}, w};
    end
    if (c == 4'd15) return 64'd0;
    if (c <= 4'd8)       n = int'(im);
    else if (c <= 4'd11) n = 32 + int'(im);
    else                 n = int'(r[5:0]);
    case (c % 3)
      0:       return x << n;
      1:       return x >> n;
      default: return ds >>> n;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c <= 4'd2)  return "R2";
    if (c <= 4'd5)  return "R4";
    if (c <= 4'd11) return "R6";
    if (c <= 4'd14) return "R5";
    return "R9";
  endfunction

  task automatic drive(input logic [3:0] c, input logic [63:0] x,
                       input logic [63:0] r, input logic [4:0] im);
    @(negedge clk);
    op = c; a = x; s = r; imm = im;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (op %0d a %h s %h imm %0d)",
               tag, got, exp, op, a, s, imm);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r0, r1, x;
    void'($urandom(32'd4242));
    op = '0; a = '0; s = '0; imm = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 idle", y, 64'd0);

    // R1: encoding spot check, code 6 is doubleword left by immediate
    drive(4'd6, 64'd1, 64'd0, 5'd4);
    check("R1", y, 64'd16);
    drive(4'd9, 64'd1, 64'd0, 5'd0);
    check("R1", y, 64'h0000_0001_0000_0000);

    // R2: upper operand bits do not matter in word forms
    drive(4'd2, 64'h0000_0000_8000_00F0, 64'd0, 5'd4);
    r0 = y;
    drive(4'd2, 64'hDEAD_BEEF_8000_00F0, 64'd0, 5'd4);
    check("R2", y, r0);
    check("R2", y, 64'hFFFF_FFFF_F800_000F);

    // R3: logical right word, bit 31 set, count 0 and 1
    drive(4'd1, 64'h0000_0000_8000_0000, 64'd0, 5'd0);
    check("R3", y, 64'hFFFF_FFFF_8000_0000);
    drive(4'd1, 64'hFFFF_FFFF_8000_0000, 64'd0, 5'd1);
    check("R3", y, 64'h0000_0000_4000_0000);
    drive(4'd0, 64'd1, 64'd0, 5'd31);
    check("R3", y, 64'hFFFF_FFFF_8000_0000);

    // R7: fill rules at full doubleword distance
    drive(4'd11, 64'h8000_0000_0000_0000, 64'd0, 5'd31);
    check("R7", y, 64'hFFFF_FFFF_FFFF_FFFF);
    drive(4'd10, 64'h8000_0000_0000_0000, 64'd0, 5'd31);
    check("R7", y, 64'd1);
    drive(4'd14, 64'h7000_0000_0000_0000, 64'h0000_0000_0000_0004, 5'd0);
    check("R7", y, 64'h0700_0000_0000_0000);

    // R8: zero count
    drive(4'd12, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFC0, 5'd7);
    check("R8", y, 64'h1234_5678_9ABC_DEF0);
    drive(4'd3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFE0, 5'd7);
    check("R8", y, 64'hFFFF_FFFF_9ABC_DEF0);

    // R9: unused code
    drive(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31);
    check("R9", y, 64'd0);

    // R10: the unused count source has no effect
    drive(4'd13, 64'hF0F0_0000_1111_2222, 64'd8, 5'd0);
    r0 = y;
    drive(4'd13, 64'hF0F0_0000_1111_2222, 64'd8, 5'd19);
    check("R10", y, r0);
    drive(4'd7, 64'hF0F0_0000_1111_2222, 64'd0, 5'd8);
    r1 = y;
    drive(4'd7, 64'hF0F0_0000_1111_2222, 64'hFFFF_FFFF_FFFF_FFFF, 5'd8);
    check("R10", y, r1);
    check("R10", y, r0);

    // sweeps over every code and every immediate / low register count
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 32; k++) begin
        for (int rep = 0; rep < 3; rep++) begin
          x  = {$urandom(), $urandom()};
          if (rep == 0) x[31] = 1'b1;
          r0 = {$urandom(), $urandom()};
          r0[4:0] = 5'(k);
          drive(4'(c), x, r0, 5'($urandom()));
          if (c <= 2 || (c >= 6 && c <= 11)) drive(4'(c), x, r0, 5'(k));
          check(tag_of(4'(c)), y, model(4'(c), x, r0, imm));
        end
      end
    end

    // R5: doubleword register counts 0..63, upper source bits random
    for (int c = 12; c < 15; c++) begin
      for (int k = 0; k < 64; k++) begin
        x  = {$urandom(), $urandom()};
        r0 = {$urandom(), $urandom()};
        r0[5:0] = 6'(k);
        drive(4'(c), x, r0, 5'($urandom()));
        check("R5", y, model(4'(c), x, r0, imm));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule